// File: doc/BRIEF.md
# Packet Buffer Descriptor Lookup Unit

This unit finds where an endpoint's buffer lies in a shared 16-bit packet memory. A descriptor table sits in that memory. Its start is given by a byte-valued table base, and each endpoint owns four consecutive 16-bit words. On a start pulse the unit reads two of the endpoint's words: the buffer-address word and then the count word of the selected direction. It reports the buffer's memory word address, the count field it read and, for the receive direction, the capacity that the count word encodes.

When write-back is requested on a receive lookup, the unit stores the byte count it got from the serial engine into the receive count word. The upper allocation bits of that word are kept. If the packet is longer than the allocation, the stored count is clipped to the capacity and an overflow pulse is raised. The parameter `PMA_BYTES` sets how packet memory is addressed. A 1024-byte memory uses every 16-bit location, and a 512-byte memory uses every second location (stride 2).

Top module: `pbuf_desc_lookup`

## Requirements
- R1: The descriptor word for endpoint `ep` and slot `s` lives at index `(tbl_base >> 1) + 4*ep + s`, which is driven on `mem_addr` as index times stride. The slots are 0 = transmit address, 1 = transmit count, 2 = receive address, 3 = receive count. The stride is 1 for `PMA_BYTES`=1024 and 2 for 512.
- R2: A start sampled in idle produces exactly two read cycles on consecutive edges: first the address word, then the count word. After them `done` is high for exactly one cycle, beginning on the third rising edge after the edge that sampled start. The read data is taken one cycle after its address.
- R3: The address word is a byte offset with bit 0 ignored. `buf_addr` equals `(addr_word >> 1)` times the stride.
- R4: When bit 15 of the receive count word is 1, the capacity is (bits 14:10 + 1) times 32 bytes, giving 32 to 1024.
- R5: When bit 15 of the receive count word is 0, the capacity is bits 14:10 times 2 bytes, giving 0 to 62.
- R6: For a transmit lookup (`dir_rx`=0), `rx_cap` is 0, `cnt_field` is bits 9:0 of the transmit count word, and nothing is written, even if `wb_en` is 1.
- R7: For a receive lookup with `wb_en`=1, one write to the receive count word is made in the cycle after the count read. It stores `rx_bytes` in bits 9:0 and keeps bits 15:10 as read.
- R8: When `rx_bytes` exceeds the decoded capacity on a write-back, `ovf` pulses together with `done`, and the stored count is the capacity. A count equal to the capacity does not overflow.
- R9: A start that arrives while a lookup is in progress is ignored. The results are those of the running lookup, and no further read follows it.
- R10: While reset is applied and after it, before any lookup, `done`, `ovf`, `mem_rd` and `mem_wr` are 0, and `buf_addr`, `rx_cap` and `cnt_field` are 0.
- R11: A receive lookup with `wb_en`=0 reports the capacity and `cnt_field` but writes nothing and never raises `ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a lookup (sampled in idle only) |
| tbl_base | input | 16 | Byte base of the descriptor table |
| ep_num | input | EP_W | Endpoint number |
| dir_rx | input | 1 | 1 = receive slots, 0 = transmit slots |
| wb_en | input | 1 | Store `rx_bytes` into the receive count word |
| rx_bytes | input | 10 | Received byte count from the serial engine |
| mem_addr | output | MEM_AW | Packet memory word address |
| mem_rd | output | 1 | Read strobe, data returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle completion pulse |
| buf_addr | output | MEM_AW | Memory word address of the endpoint buffer |
| rx_cap | output | 11 | Decoded receive capacity in bytes |
| cnt_field | output | 10 | Bits 9:0 of the count word as read |
| ovf | output | 1 | Overflow pulse on write-back |

## Verification
The checker takes for granted that the packet memory answers a read on the following cycle and does nothing without a strobe. It therefore only ties the sequencer's strobes, the completion pulse and the capacity range to each other, and never to the data values. The bench's memory model has exactly that one-cycle read latency. It fills every descriptor word the unit might reach with count words in the legal encoding, and the remaining locations with a distinct pattern, so a wrong address shows up as a wrong result. Start is only raised in idle, except in the directed test of R9, which holds it high through the busy cycles on purpose.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_CNT  = 2'd2,
    ST_DONE = 2'd3
  } pbd_state_e;

  localparam int CNT_W = 10;
  localparam int CAP_W = 11;
  localparam int WORD_W = 16;
endpackage

// File: rtl/pbd_addr_map.sv
module pbd_addr_map #(
  parameter int STRIDE = 1,
  parameter int LW = 9,
  parameter int AW = 9
) (
  input  logic [LW-1:0] idx,
  output logic [AW-1:0] addr
);
  generate
    if (STRIDE == 2) begin : g_stride2
      assign addr = {idx, 1'b0};
    end else begin : g_stride1
      assign addr = idx;
    end
  endgenerate
endmodule

// File: rtl/pbd_cap_decode.sv
module pbd_cap_decode
  import pbd_pkg::*;
(
  input  logic [5:0]       alloc,
  output logic [CAP_W-1:0] cap
);
  logic             big_blk;
  logic [4:0]       nblk;

  assign big_blk = alloc[5];
  assign nblk    = alloc[4:0];

  always_comb begin
    if (big_blk) begin
      cap = (CAP_W'(nblk) + CAP_W'(1)) << 5;
    end else begin
      cap = CAP_W'({nblk, 1'b0});
    end
  end
endmodule

// File: rtl/pbd_seq.sv
module pbd_seq
  import pbd_pkg::*;
#(
  parameter int EP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EP_W-1:0]   ep_num,
  input  logic              dir_rx,
  input  logic              wb_en,
  input  logic [CNT_W-1:0]  rx_bytes,
  input  logic [WORD_W-1:0] rdata,
  input  logic [CAP_W-1:0]  cap_dec,
  output logic [1:0]        slot,
  output logic [EP_W-1:0]   ep_q,
  output logic [WORD_W-1:0] addr_word_q,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic              ovf,
  output logic [CAP_W-1:0]  cap_q,
  output logic [CNT_W-1:0]  cnt_q
);
  pbd_state_e        st_q, st_n;
  logic [EP_W-1:0]   ep_n;
  logic              rx_q, rx_n, wb_q, wb_n;
  logic [CNT_W-1:0]  bytes_q, bytes_n;
  logic [WORD_W-1:0] aw_n;
  logic              done_n, ovf_n;
  logic [CAP_W-1:0]  cap_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              too_long;
  logic [CNT_W-1:0]  wcnt;

  assign too_long  = {1'b0, bytes_q} > cap_dec;
  assign wcnt      = too_long ? cap_dec[CNT_W-1:0] : bytes_q;
  assign mem_rd    = (st_q == ST_ADDR) || (st_q == ST_CNT);
  assign mem_wr    = (st_q == ST_DONE) && rx_q && wb_q;
  assign mem_wdata = {rdata[WORD_W-1:CNT_W], wcnt};
  assign slot      = {rx_q, (st_q != ST_ADDR)};

  always_comb begin
    st_n    = st_q;
    ep_n    = ep_q;
    rx_n    = rx_q;
    wb_n    = wb_q;
    bytes_n = bytes_q;
    aw_n    = addr_word_q;
    cap_n   = cap_q;
    cnt_n   = cnt_q;
    done_n  = 1'b0;
    ovf_n   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ep_n    = ep_num;
          rx_n    = dir_rx;
          wb_n    = wb_en;
          bytes_n = rx_bytes;
          st_n    = ST_ADDR;
        end
      end
      ST_ADDR: st_n = ST_CNT;
      ST_CNT: begin
        aw_n = rdata;
        st_n = ST_DONE;
      end
      ST_DONE: begin
        done_n = 1'b1;
        ovf_n  = rx_q && wb_q && too_long;
        cap_n  = rx_q ? cap_dec : '0;
        cnt_n  = rdata[CNT_W-1:0];
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      ep_q        <= '0;
      rx_q        <= 1'b0;
      wb_q        <= 1'b0;
      bytes_q     <= '0;
      addr_word_q <= '0;
      cap_q       <= '0;
      cnt_q       <= '0;
      done        <= 1'b0;
      ovf         <= 1'b0;
    end else begin
      st_q        <= st_n;
      ep_q        <= ep_n;
      rx_q        <= rx_n;
      wb_q        <= wb_n;
      bytes_q     <= bytes_n;
      addr_word_q <= aw_n;
      cap_q       <= cap_n;
      cnt_q       <= cnt_n;
      done        <= done_n;
      ovf         <= ovf_n;
    end
  end
endmodule

// File: rtl/pbuf_desc_lookup.sv
module pbuf_desc_lookup
  import pbd_pkg::*;
#(
  parameter int PMA_BYTES = 1024,
  parameter int EP_W = 3,
  localparam int STRIDE = (PMA_BYTES == 512) ? 2 : 1,
  localparam int LOG_AW = $clog2(PMA_BYTES / 2),
  localparam int MEM_AW = $clog2((PMA_BYTES / 2) * STRIDE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       tbl_base,
  input  logic [EP_W-1:0]   ep_num,
  input  logic              dir_rx,
  input  logic              wb_en,
  input  logic [9:0]        rx_bytes,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              done,
  output logic [MEM_AW-1:0] buf_addr,
  output logic [10:0]       rx_cap,
  output logic [9:0]        cnt_field,
  output logic              ovf
);
  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic [1:0]        slot;
  logic [EP_W-1:0]   ep_q;
  logic [15:0]       addr_word_q;
  logic [CAP_W-1:0]  cap_dec;
  logic [LOG_AW-1:0] desc_idx;
  logic [LOG_AW-1:0] buf_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign desc_idx = tbl_base[LOG_AW:1] + (LOG_AW'(ep_q) << 2) + LOG_AW'(slot);
  assign buf_idx  = addr_word_q[LOG_AW:1];

  pbd_addr_map #(.STRIDE(STRIDE), .LW(LOG_AW), .AW(MEM_AW)) u_desc_map (
    .idx (desc_idx),
    .addr(mem_addr)
  );

  pbd_addr_map #(.STRIDE(STRIDE), .LW(LOG_AW), .AW(MEM_AW)) u_buf_map (
    .idx (buf_idx),
    .addr(buf_addr)
  );

  pbd_cap_decode u_cap (
    .alloc(mem_rdata[15:10]),
    .cap  (cap_dec)
  );

  pbd_seq #(.EP_W(EP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .ep_num     (ep_num),
    .dir_rx     (dir_rx),
    .wb_en      (wb_en),
    .rx_bytes   (rx_bytes),
    .rdata      (mem_rdata),
    .cap_dec    (cap_dec),
    .slot       (slot),
    .ep_q       (ep_q),
    .addr_word_q(addr_word_q),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_wdata  (mem_wdata),
    .done       (done),
    .ovf        (ovf),
    .cap_q      (rx_cap),
    .cnt_q      (cnt_field)
  );
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        done,
  input logic        ovf,
  input logic [10:0] rx_cap
);
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_two_reads_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_rd, 2) && $past(mem_rd, 3) && !$past(mem_rd, 1)));

  a_r9_no_third_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |=> !mem_rd);

  a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r7_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done);

  a_r8_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> done);

  a_r4_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rx_cap <= 11'd1024));
endmodule

bind pbuf_desc_lookup pbd_checker u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .mem_rd(mem_rd),
  .mem_wr(mem_wr),
  .done  (done),
  .ovf   (ovf),
  .rx_cap(rx_cap)
);

// File: tb/sim_pbuf_desc_lookup.sv
module sim_pbuf_desc_lookup;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] tbl_base;
  logic [2:0]  ep_num;
  logic        dir_rx;
  logic        wb_en;
  logic [9:0]  rx_bytes;
  logic [8:0]  mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        done;
  logic [8:0]  buf_addr;
  logic [10:0] rx_cap;
  logic [9:0]  cnt_field;
  logic        ovf;

  int n_chk;
  int n_fail;

  logic [15:0] ram [512];

  pbuf_desc_lookup u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .ep_num(ep_num), .dir_rx(dir_rx), .wb_en(wb_en), .rx_bytes(rx_bytes),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .buf_addr(buf_addr), .rx_cap(rx_cap), .cnt_field(cnt_field), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  typedef struct packed {
    logic [15:0] base;
    logic [2:0]  ep;
    logic        rx;
    logic        wb;
    logic [9:0]  rxb;
    logic [15:0] aw;
    logic [15:0] cw;
    logic [8:0]  ebuf;
    logic [10:0] ecap;
    logic [9:0]  ecnt;
    logic        eovf;
    logic        ewr;
    logic [15:0] ewd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{16'h0040, 3'd0, 1'b0, 1'b0, 10'd0,    16'h0080, 16'h0040, 9'h040, 11'd0,    10'h040, 1'b0, 1'b0, 16'h0000},
    '{16'h0040, 3'd1, 1'b1, 1'b1, 10'd50,   16'h0100, 16'h7C00, 9'h080, 11'd62,   10'h000, 1'b0, 1'b1, 16'h7C32},
    '{16'h0040, 3'd2, 1'b1, 1'b1, 10'd100,  16'h0181, 16'h8400, 9'h0C0, 11'd64,   10'h000, 1'b1, 1'b1, 16'h8440},
    '{16'h0040, 3'd3, 1'b1, 1'b1, 10'd64,   16'h0200, 16'h87FF, 9'h100, 11'd64,   10'h3FF, 1'b0, 1'b1, 16'h8440},
    '{16'h0000, 3'd7, 1'b1, 1'b0, 10'd999,  16'h03FE, 16'hFC00, 9'h1FF, 11'd1024, 10'h000, 1'b0, 1'b0, 16'h0000},
    '{16'h0100, 3'd5, 1'b1, 1'b1, 10'd1023, 16'h0010, 16'hFC00, 9'h008, 11'd1024, 10'h000, 1'b0, 1'b1, 16'hFFFF},
    '{16'h0080, 3'd4, 1'b1, 1'b1, 10'd3,    16'h0020, 16'h0400, 9'h010, 11'd2,    10'h000, 1'b1, 1'b1, 16'h0402},
    '{16'h0080, 3'd6, 1'b1, 1'b1, 10'd0,    16'h0030, 16'h0005, 9'h018, 11'd0,    10'h005, 1'b0, 1'b1, 16'h0000},
    '{16'h0040, 3'd2, 1'b0, 1'b1, 10'd7,    16'h0044, 16'h83FF, 9'h022, 11'd0,    10'h3FF, 1'b0, 1'b0, 16'h0000}
  };

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  int lat;
  int rd_cnt;
  int wr_cnt;
  logic [8:0]  wr_addr;
  logic        got_ovf;
  logic [8:0]  got_buf;
  logic [10:0] got_cap;
  logic [9:0]  got_cnt;

  // Launch one lookup; hold_busy keeps start high through the busy cycles (R9).
  task automatic run(input vec_t v, input logic [2:0] busy_ep, input bit hold_busy);
    @(negedge clk);
    tbl_base = v.base; ep_num = v.ep; dir_rx = v.rx; wb_en = v.wb;
    rx_bytes = v.rxb; start = 1'b1;
    lat = 0; rd_cnt = 0; wr_cnt = 0; wr_addr = '0; got_ovf = 1'b0;
    got_buf = '0; got_cap = '0; got_cnt = '0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (!hold_busy || k >= 3) start = 1'b0;
      else begin ep_num = busy_ep; rx_bytes = 10'd1; end
      if (mem_rd) rd_cnt++;
      if (mem_wr) begin wr_cnt++; wr_addr = mem_addr; end
      if (done) begin
        lat = k; got_ovf = ovf; got_buf = buf_addr;
        got_cap = rx_cap; got_cnt = cnt_field;
        break;
      end
    end
    start = 1'b0;
  endtask

  task automatic apply(input vec_t v, input logic [2:0] busy_ep, input bit hold_busy);
    int didx;
    int aidx;
    int cidx;
    didx = int'(v.base >> 1) + int'(v.ep) * 4;
    aidx = didx + (v.rx ? 2 : 0);
    cidx = didx + (v.rx ? 3 : 1);
    ram[aidx] = v.aw;
    ram[cidx] = v.cw;
    run(v, busy_ep, hold_busy);
    chk("R2 done latency", lat, 4);
    chk("R2 read cycles", rd_cnt, 2);
    chk("R1/R3 buffer address", got_buf, v.ebuf);
    chk(v.cw[15] ? "R4 capacity" : "R5 capacity", got_cap, v.ecap);
    chk("R6/R11 count field", got_cnt, v.ecnt);
    chk("R8 overflow", got_ovf, v.eovf);
    if (v.ewr) begin
      chk("R7 one write", wr_cnt, 1);
      chk("R1 write address", wr_addr, 9'(cidx));
      chk("R7 stored count word", ram[cidx], v.ewd);
    end else begin
      chk("R6/R11 no write", wr_cnt, 0);
      chk("R6/R11 count word kept", ram[cidx], v.cw);
    end
    @(negedge clk);
    chk("R2 done single cycle", done, 1'b0);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  initial begin
    vec_t vb;
    n_chk = 0; n_fail = 0;
    for (int i = 0; i < 512; i++) ram[i] = 16'h5A00 ^ 16'(i);
    start = 1'b0; tbl_base = '0; ep_num = '0; dir_rx = 1'b0;
    wb_en = 1'b0; rx_bytes = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk("R10 done in reset", done, 1'b0);
    chk("R10 ovf in reset", ovf, 1'b0);
    chk("R10 mem_rd in reset", mem_rd, 1'b0);
    chk("R10 mem_wr in reset", mem_wr, 1'b0);
    chk("R10 buf_addr in reset", buf_addr, 9'd0);
    chk("R10 rx_cap in reset", rx_cap, 11'd0);
    chk("R10 cnt_field in reset", cnt_field, 10'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle after reset", {done, ovf, mem_rd, mem_wr}, 4'b0000);

    for (int i = 0; i < NV; i++) apply(VEC[i], 3'd0, 1'b0);

    // R9: start held high through the busy cycles with another endpoint
    ram[(16'h0040 >> 1) + 5*4 + 2] = 16'h0300;
    ram[(16'h0040 >> 1) + 5*4 + 3] = 16'h0C00;
    vb = VEC[2];
    apply(vb, 3'd5, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk("R9 no read after busy start", mem_rd, 1'b0);
    end

    summary_and_end();
  end
endmodule